// File: doc/BRIEF.md
# Privileged Interrupt Pending Selector

This block decides which local interrupt a hart takes next. It gets three per-source vectors: pending, enable and delegation. It also gets the current privilege level and two global enable bits, one for machine level and one for supervisor level. From these it produces a single "take" flag and the cause number of the winning source. The block does not produce pending bits and does not carry out the trap entry. It only makes the selection.

A source is a candidate when both its pending bit and its enable bit are set. A candidate whose delegation bit is clear belongs to machine level. A candidate whose delegation bit is set belongs to supervisor level. A candidate can be taken only while its own level is globally open. A level is open when the hart runs below that level, or when it runs at exactly that level with the matching global enable set. Among the candidates that may be taken, the lowest source index wins.

The selection is a plain control path. Its pins have no valid/ready handshake and no back-pressure: the outputs always follow the inputs. A parameter chooses between two variants. One drives the result straight from the inputs in the same cycle. The other adds one register stage on the result.

Top module: `hart_irq_select`

## Requirements
- R1: A source whose pending bit or enable bit is clear is never selected, whatever its delegation bit and the privilege level.
- R2: Privilege is encoded U=0, S=1, M=3. An undelegated candidate (delegation bit 0) may be taken when the privilege is not 3. At privilege 3 it may be taken only when the machine global enable is 1. The supervisor global enable has no effect on it.
- R3: A delegated candidate (delegation bit 1) may be taken when the privilege is 0 or 2. At privilege 1 it may be taken only when the supervisor global enable is 1. At privilege 3 it is never taken. The machine global enable has no effect on it.
- R4: Privilege code 2 gives exactly the same result as code 0 for every input pattern.
- R5: When several sources may be taken, cause_o is the lowest such bit index, written as an unsigned binary number, and take_o is 1.
- R6: When no source may be taken, take_o is 0 and cause_o is 0.
- R7: With OUT_REG=0, take_o and cause_o follow the inputs in the same cycle.
- R8: With OUT_REG=1, take_o and cause_o show the result for the inputs present at the previous rising clock edge. While rst_n is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| pend_i | input | NUM_IRQ | Pending bit per interrupt source |
| en_i | input | NUM_IRQ | Enable bit per interrupt source |
| deleg_i | input | NUM_IRQ | 1 = source handled at supervisor level, 0 = machine level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine, 2 treated as user |
| m_gie_i | input | 1 | Machine-level global interrupt enable |
| s_gie_i | input | 1 | Supervisor-level global interrupt enable |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | $clog2(NUM_IRQ) | Index of the selected source, 0 when none |

## Verification
In the combinational variant, the result is due as soon as the inputs settle. The bench applies each input pattern just after a falling edge and checks one time unit later, still inside the same low phase. In the registered variant, the result for a pattern is due at the first rising edge after that pattern is applied. The bench therefore checks that instance at the next falling edge, before it applies new inputs, against the expectation it computed when it drove the pattern. The reset check is made while rst_n is still held low, with every source pending, enabled and open.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;
endpackage

// File: rtl/irq_sel_gate.sv
module irq_sel_gate
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic [NUM_IRQ-1:0] elig_o
);
  lvl_e               lvl;
  logic               m_open, s_open;
  logic [NUM_IRQ-1:0] cand;

  always_comb begin
    lvl    = lvl_e'(priv_i);
    cand   = pend_i & en_i;
    m_open = (lvl != LVL_MACH) || m_gie_i;
    unique case (lvl)
      LVL_USER, LVL_RSVD: s_open = 1'b1;
      LVL_SUPER:          s_open = s_gie_i;
      default:            s_open = 1'b0;
    endcase
    elig_o = cand & ((~deleg_i & {NUM_IRQ{m_open}}) |
                     ( deleg_i & {NUM_IRQ{s_open}}));
  end

  // R1
  no_uncand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_o & ~(pend_i & en_i)) == '0);
  // R2
  m_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd3 && !m_gie_i) |-> ((elig_o & ~deleg_i) == '0));
  // R3
  s_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd3) |-> ((elig_o & deleg_i) == '0));
  // R4
  rsvd_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd2) |-> (elig_o == (pend_i & en_i)));
endmodule

// File: rtl/irq_sel_ctz.sv
module irq_sel_ctz #(
  parameter int NUM_IRQ = 16,
  localparam int CW = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] elig_i,
  output logic               take_o,
  output logic [CW-1:0]      cause_o
);
  always_comb begin
    take_o  = |elig_i;
    cause_o = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (elig_i[i]) cause_o = CW'(i);
    end
  end

  // R5
  win_is_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> elig_i[cause_o]);
  // R5
  no_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((elig_i & ~({NUM_IRQ{1'b1}} << cause_o)) == '0));
  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_i == '0) |-> (!take_o && cause_o == '0));
endmodule

// File: rtl/irq_sel_outreg.sv
module irq_sel_outreg #(
  parameter int CW      = 4,
  parameter bit OUT_REG = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_d,
  input  logic [CW-1:0] cause_d,
  output logic          take_o,
  output logic [CW-1:0] cause_o
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          take_o  <= 1'b0;
          cause_o <= '0;
        end else begin
          take_o  <= take_d;
          cause_o <= cause_d;
        end
      end
      // R8
      reg_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (take_o == $past(take_d) && cause_o == $past(cause_d)));
    end else begin : g_comb
      assign take_o  = take_d;
      assign cause_o = cause_d;
    end
  endgenerate

  // R6
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (cause_o == '0));
endmodule

// File: rtl/hart_irq_select.sv
module hart_irq_select #(
  parameter int NUM_IRQ = 16,
  parameter bit OUT_REG = 1'b0,
  localparam int CW = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic               take_o,
  output logic [CW-1:0]      cause_o
);
  logic [NUM_IRQ-1:0] elig;
  logic               take_c;
  logic [CW-1:0]      cause_c;

  irq_sel_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i),
    .deleg_i(deleg_i), .priv_i(priv_i), .m_gie_i(m_gie_i),
    .s_gie_i(s_gie_i), .elig_o(elig)
  );

  irq_sel_ctz #(.NUM_IRQ(NUM_IRQ)) u_ctz (
    .clk(clk), .rst_n(rst_n), .elig_i(elig),
    .take_o(take_c), .cause_o(cause_c)
  );

  irq_sel_outreg #(.CW(CW), .OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n), .take_d(take_c), .cause_d(cause_c),
    .take_o(take_o), .cause_o(cause_o)
  );
endmodule

// File: tb/test_hart_irq_select.sv
module test_hart_irq_select;
  localparam int N  = 16;
  localparam int CW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend = '0, en = '0, deleg = '0;
  logic [1:0]    priv = 2'd0;
  logic          mg = 1'b0, sg = 1'b0;
  logic          take_c, take_q;
  logic [CW-1:0] cause_c, cause_q;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit held_ok = 1'b0;
  int held_exp = 0;

  always #10 clk = ~clk;

  hart_irq_select #(.NUM_IRQ(N), .OUT_REG(1'b0)) i_hart_irq_select (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .m_gie_i(mg), .s_gie_i(sg),
    .take_o(take_c), .cause_o(cause_c));

  hart_irq_select #(.NUM_IRQ(N), .OUT_REG(1'b1)) i_hart_irq_select_q (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .m_gie_i(mg), .s_gie_i(sg),
    .take_o(take_q), .cause_o(cause_q));

  // reference: returns -1 for none, else the winning index
  function automatic int ref_pick(logic [N-1:0] p, logic [N-1:0] e,
                                  logic [N-1:0] d, int pv, bit m, bit s);
    bit m_ok, s_ok;
    m_ok = (pv != 3) || m;
    s_ok = (pv == 0) || (pv == 2) || (pv == 1 && s);
    for (int k = 0; k < N; k++) begin
      if (p[k] && e[k] && ((!d[k] && m_ok) || (d[k] && s_ok))) return k;
    end
    return -1;
  endfunction

  task automatic check(string tag, logic t, logic [CW-1:0] c, int exp);
    logic          et;
    logic [CW-1:0] ec;
    et = (exp >= 0);
    ec = et ? CW'(exp) : '0;
    n_chk++;
    if (t !== et || c !== ec) begin
      n_fail++;
      $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
               tag, t, c, et, ec);
    end
  endtask

  task automatic apply(string tag, logic [N-1:0] p, logic [N-1:0] e,
                       logic [N-1:0] d, int pv, bit m, bit s);
    int exp;
    @(negedge clk);
    if (held_ok) check("R8 registered", take_q, cause_q, held_exp);
    pend = p; en = e; deleg = d; priv = pv[1:0]; mg = m; sg = s;
    exp = ref_pick(p, e, d, pv, m, s);
    #1;
    check({tag, " R7 comb"}, take_c, cause_c, exp);
    held_exp = exp;
    held_ok  = 1'b1;
  endtask

  initial begin
    // R8 reset: everything open, registered output must stay 0
    pend = '1; en = '1; deleg = '0; priv = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset", take_q, cause_q, -1);
    rst_n = 1'b1;

    // R1: pending without enable, enable without pending
    apply("R1", 16'hFFFF, 16'h0000, 16'h0000, 0, 1, 1);
    apply("R1", 16'h0000, 16'hFFFF, 16'hFFFF, 0, 1, 1);
    apply("R1", 16'h00F0, 16'h0F80, 16'h0000, 0, 1, 1);
    // R6: nothing pending at all
    apply("R6", 16'h0000, 16'h0000, 16'h0000, 3, 1, 1);
    // R2: machine level
    apply("R2", 16'h0024, 16'hFFFF, 16'h0000, 3, 0, 1);
    apply("R2", 16'h0024, 16'hFFFF, 16'h0000, 3, 1, 0);
    apply("R2", 16'h0024, 16'hFFFF, 16'h0000, 1, 0, 0);
    apply("R2", 16'h0024, 16'hFFFF, 16'h0000, 0, 0, 0);
    // R3: supervisor level
    apply("R3", 16'h0300, 16'hFFFF, 16'hFFFF, 3, 1, 1);
    apply("R3", 16'h0300, 16'hFFFF, 16'hFFFF, 1, 1, 0);
    apply("R3", 16'h0300, 16'hFFFF, 16'hFFFF, 1, 0, 1);
    apply("R3", 16'h0300, 16'hFFFF, 16'hFFFF, 0, 0, 0);
    // R3 mixed: delegated low bit blocked, undelegated higher bit wins
    apply("R3", 16'h8001, 16'hFFFF, 16'h0001, 1, 1, 0);
    // R4: reserved code behaves as user
    apply("R4", 16'h0300, 16'hFFFF, 16'h0100, 2, 0, 0);
    apply("R4", 16'hA000, 16'hFFFF, 16'h2000, 2, 0, 0);
    // R5: lowest index wins, top and bottom boundaries
    apply("R5", 16'hFFFF, 16'hFFFF, 16'h0000, 0, 0, 0);
    apply("R5", 16'h8000, 16'hFFFF, 16'h0000, 0, 0, 0);
    apply("R5", 16'hF0F0, 16'h7FE0, 16'h0000, 3, 1, 0);

    // sweep: every privilege code and enable pair over several delegation patterns
    for (int pv = 0; pv < 4; pv++) begin
      for (int gm = 0; gm < 2; gm++) begin
        for (int gs = 0; gs < 2; gs++) begin
          apply("R2/R3 sweep", 16'h5A5A, 16'hFFFF, 16'h0000, pv, gm[0], gs[0]);
          apply("R2/R3 sweep", 16'h5A5A, 16'hFFFF, 16'hFFFF, pv, gm[0], gs[0]);
          apply("R2/R3 sweep", 16'h5A5A, 16'hFFFF, 16'h00FF, pv, gm[0], gs[0]);
          apply("R2/R3 sweep", 16'h5A5A, 16'hFFFF, 16'hFF00, pv, gm[0], gs[0]);
        end
      end
    end

    // random patterns with some sparse pending vectors
    for (int r = 0; r < 400; r++) begin
      logic [N-1:0] rp;
      rp = N'($urandom);
      if (r % 3 == 0) rp = rp & N'($urandom) & N'($urandom);
      apply("R5 random", rp, N'($urandom), N'($urandom),
            int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
    end

    @(negedge clk);
    check("R8 registered", take_q, cause_q, held_exp);
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule